// File: doc/BRIEF.md
# Parity-Protected Write-Through Data Cache

This block is a small direct-mapped data cache placed between a processor load/store port and a plain external memory port. Every stored tag and every stored data word has its own even-parity bit. The parity bit is computed whenever the value is written. It is checked when a lookup is made. When the check fails, the line is dropped and the access is handled as an ordinary miss. The processor waits exactly as it would for any refill, and it receives correct data from external memory with no error signalled to it.

Stores always go through to external memory. A store that finds its line present also rewrites the cached word and its parity. A store that misses leaves the cache unchanged. A saturating counter records how many parity failures have been seen and has a synchronous clear. Two fault-injection inputs invert the parity bit being written, so the detection path can be exercised.

Addresses are word addresses split, from the most significant bit down, into tag, line index and word offset. The processor holds its request until it receives a one-cycle acknowledge. The memory port holds its request until the memory acknowledges it.

Top module: `pcache_wt`

## Requirements
- R1: A load that misses invalidates the line and fetches all words of the line from memory, starting at word offset 0 and rising by one per fetch. It then marks the line valid and acknowledges with the requested word.
- R2: A load to a valid line with a matching tag, a good tag parity and a good word parity acknowledges with the cached word in the cycle after the request is taken. It makes no memory request, and the acknowledge lasts one cycle.
- R3: Each parity bit is even parity: the XOR of the stored value and its parity bit is 0. It is recomputed on every write into the tag or data storage, including store hits.
- R4: A lookup of a valid line whose tag entry fails parity invalidates the line and adds one to the error count. A load is then refilled and returned correctly, with no error reported to the processor.
- R5: A lookup whose tag matches but whose requested data word fails parity is handled the same way: invalidate, add one to the count, refill, return correct data.
- R6: Every store issues exactly one memory write with the request's address and data. The memory request stays stable until acknowledged, and the processor acknowledge follows the memory acknowledge.
- R7: A store that hits writes the new word and its parity into the cache at the clock edge where the memory write request rises. A later load of that word hits with the new value.
- R8: A store that misses does not allocate or replace a line.
- R9: The 8-bit error count saturates at 255.
- R10: err_clr clears the count synchronously. If a parity error is detected in the same cycle, the count becomes 1.
- R11: fi_tag inverts the tag parity bit written when a refill completes. fi_data inverts the parity bit of every data word written while it is high.
- R12: Reset invalidates all lines, zeroes the count and leaves both request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ack |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| fi_tag | input | 1 | Invert tag parity written on refill completion |
| fi_data | input | 1 | Invert parity of data words written |
| err_clr | input | 1 | Synchronous clear of the error count |
| err_cnt | output | 8 | Saturating parity-error count |

## Verification
A parity-error detection and a synchronous clear of the error count can fall in the same cycle. In that case the clear must not swallow the new event, so the count must read 1. The bench plants a bad tag parity on one line. It then raises err_clr together with the next request to that line, so that the clear and the lookup that detects the error meet at the same edge. It judges the count after the refill. The count is also driven to saturation and checked to stay at 255.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_STORE = 2'd2,
      ST_DONE  = 2'd3
   } pc_state_e;
endpackage

// File: rtl/pc_tag_store.sv
module pc_tag_store #(
   parameter int LINES = 8,
   parameter int TAG_W = 7,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_par_ok,
   input  logic             inv_en,
   input  logic [IDX_W-1:0] inv_idx,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_flip
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W:0]   entry_q [LINES];
   logic [TAG_W:0]   rd_entry;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
      end else begin
         if (inv_en) valid_q[inv_idx] <= 1'b0;
         if (wr_en)  valid_q[wr_idx]  <= 1'b1;
      end
   end

   // even parity bit stored above the tag
   always_ff @(posedge clk) begin
      if (wr_en) entry_q[wr_idx] <= {(^wr_tag) ^ wr_flip, wr_tag};
   end

   assign rd_entry  = entry_q[rd_idx];
   assign rd_valid  = valid_q[rd_idx];
   assign rd_tag    = rd_entry[TAG_W-1:0];
   assign rd_par_ok = ~(^rd_entry);

   // R12
   reset_inval_chk: assert property (@(posedge clk) rst |=> valid_q == '0)
      else $error("valid bits not cleared by reset");
endmodule

// File: rtl/pc_data_store.sv
module pc_data_store #(
   parameter int LINES      = 8,
   parameter int LINE_WORDS = 4,
   parameter int DATA_W     = 32,
   localparam int IDX_W = $clog2(LINES),
   localparam int OFF_W = $clog2(LINE_WORDS),
   localparam int DEPTH = LINES * LINE_WORDS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_par_ok,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_flip
);
   logic [DATA_W:0] word_q [DEPTH];
   logic [DATA_W:0] rd_word;
   logic            wr_par;

   assign wr_par = (^wr_data) ^ wr_flip;

   always_ff @(posedge clk) begin
      if (wr_en) word_q[{wr_idx, wr_off}] <= {wr_par, wr_data};
   end

   assign rd_word   = word_q[{rd_idx, rd_off}];
   assign rd_data   = rd_word[DATA_W-1:0];
   assign rd_par_ok = ~(^rd_word);
endmodule

// File: rtl/pc_err_counter.sv
module pc_err_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                          cnt_q <= '0;
      else if (clr)                     cnt_q <= CNT_W'(inc);
      else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

   // R9
   sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX)
      else $error("error count wrapped");
   // R10
   clr_result_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> cnt_q <= CNT_W'(1))
      else $error("clear did not take effect");
endmodule

// File: rtl/pcache_wt.sv
module pcache_wt #(
   parameter int ADDR_W        = 12,
   parameter int DATA_W        = 32,
   parameter int LINE_WORDS    = 4,
   parameter int LINES         = 8,
   parameter int CNT_W         = 8,
   parameter bit WRITE_THROUGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              fi_tag,
   input  logic              fi_data,
   input  logic              err_clr,
   output logic [CNT_W-1:0]  err_cnt
);
   import pcache_pkg::*;

   localparam int OFF_W = $clog2(LINE_WORDS);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

   generate
      if (!WRITE_THROUGH) begin : g_bad_policy
         $error("only write-through operation is supported with parity protection");
      end
      if ((1 << OFF_W) != LINE_WORDS || LINE_WORDS < 2) begin : g_bad_line
         $error("LINE_WORDS must be a power of two, at least 2");
      end
      if ((1 << IDX_W) != LINES || LINES < 2) begin : g_bad_lines
         $error("LINES must be a power of two, at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("ADDR_W too small for the chosen geometry");
      end
   endgenerate

   pc_state_e         state_q;
   logic [ADDR_W-1:0] req_addr_q;
   logic [DATA_W-1:0] req_wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic [OFF_W-1:0]  fill_cnt_q;

   logic [OFF_W-1:0]  a_off, q_off;
   logic [IDX_W-1:0]  a_idx, q_idx;
   logic [TAG_W-1:0]  a_tag, q_tag;

   assign {a_tag, a_idx, a_off} = cpu_addr;
   assign {q_tag, q_idx, q_off} = req_addr_q;

   // lookup results
   logic              t_valid, t_par_ok;
   logic [TAG_W-1:0]  t_tag;
   logic [DATA_W-1:0] d_data;
   logic              d_par_ok;
   logic              take, tag_err, tag_hit, data_err, load_hit, err_inc;

   assign take     = (state_q == ST_IDLE) && cpu_req;
   assign tag_err  = t_valid && !t_par_ok;
   assign tag_hit  = t_valid && t_par_ok && (t_tag == a_tag);
   assign data_err = tag_hit && !cpu_we && !d_par_ok;
   assign load_hit = tag_hit && !cpu_we && d_par_ok;
   assign err_inc  = take && (tag_err || data_err);

   // storage write controls
   logic              inv_en, tag_wr;
   logic              dat_wr;
   logic [IDX_W-1:0]  dat_idx;
   logic [OFF_W-1:0]  dat_off;
   logic [DATA_W-1:0] dat_val;
   logic              fill_beat;

   assign fill_beat = (state_q == ST_FILL) && mem_ack;
   assign inv_en    = take && (tag_err || data_err || (!cpu_we && !load_hit));
   assign tag_wr    = fill_beat && (fill_cnt_q == LAST_OFF);

   always_comb begin
      dat_wr  = 1'b0;
      dat_idx = a_idx;
      dat_off = a_off;
      dat_val = cpu_wdata;
      if (fill_beat) begin
         dat_wr  = 1'b1;
         dat_idx = q_idx;
         dat_off = fill_cnt_q;
         dat_val = mem_rdata;
      end else if (take && cpu_we && tag_hit) begin
         dat_wr  = 1'b1;
      end
   end

   pc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
      .clk       (clk),
      .rst       (rst),
      .rd_idx    (a_idx),
      .rd_valid  (t_valid),
      .rd_tag    (t_tag),
      .rd_par_ok (t_par_ok),
      .inv_en    (inv_en),
      .inv_idx   (a_idx),
      .wr_en     (tag_wr),
      .wr_idx    (q_idx),
      .wr_tag    (q_tag),
      .wr_flip   (fi_tag)
   );

   pc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) i_data (
      .clk       (clk),
      .rd_idx    (a_idx),
      .rd_off    (a_off),
      .rd_data   (d_data),
      .rd_par_ok (d_par_ok),
      .wr_en     (dat_wr),
      .wr_idx    (dat_idx),
      .wr_off    (dat_off),
      .wr_data   (dat_val),
      .wr_flip   (fi_data)
   );

   pc_err_counter #(.CNT_W(CNT_W)) i_errs (
      .clk (clk),
      .rst (rst),
      .clr (err_clr),
      .inc (err_inc),
      .cnt (err_cnt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         req_addr_q  <= '0;
         req_wdata_q <= '0;
         rdata_q     <= '0;
         fill_cnt_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (cpu_req) begin
               req_addr_q  <= cpu_addr;
               req_wdata_q <= cpu_wdata;
               fill_cnt_q  <= '0;
               if (cpu_we) begin
                  state_q <= ST_STORE;
               end else if (load_hit) begin
                  rdata_q <= d_data;
                  state_q <= ST_DONE;
               end else begin
                  state_q <= ST_FILL;
               end
            end
            ST_FILL: if (mem_ack) begin
               if (fill_cnt_q == q_off) rdata_q <= mem_rdata;
               fill_cnt_q <= fill_cnt_q + 1'b1;
               if (fill_cnt_q == LAST_OFF) state_q <= ST_DONE;
            end
            ST_STORE: if (mem_ack) state_q <= ST_DONE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ack   = (state_q == ST_DONE);
   assign cpu_rdata = rdata_q;
   assign mem_req   = (state_q == ST_FILL) || (state_q == ST_STORE);
   assign mem_we    = (state_q == ST_STORE);
   assign mem_addr  = (state_q == ST_FILL) ? {q_tag, q_idx, fill_cnt_q} : req_addr_q;
   assign mem_wdata = req_wdata_q;

   // R6
   mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
      else $error("memory request changed before acknowledge");
   // R1
   fill_order_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_we && mem_ack && mem_addr[OFF_W-1:0] != LAST_OFF) |=>
      (mem_req && !mem_we &&
       mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1)))
      else $error("refill order broken");
   // R2
   ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_ack |=> !cpu_ack)
      else $error("acknowledge longer than one cycle");
   // R4
   err_refill_chk: assert property (@(posedge clk) disable iff (rst)
      (err_inc && !cpu_we) |=> (mem_req && !mem_we && !cpu_ack))
      else $error("parity error on load not turned into refill");
   // R12
   idle_after_reset_chk: assert property (@(posedge clk)
      rst |=> (!mem_req && !cpu_ack))
      else $error("requests active after reset");
endmodule

// File: tb/test_pcache_wt.sv
module test_pcache_wt;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [11:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ack;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [11:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        fi_tag = 1'b0, fi_data = 1'b0, err_clr = 1'b0;
   logic [7:0]  err_cnt;

   always #2 clk = ~clk;

   pcache_wt i_pcache_wt (
      .clk(clk), .rst(rst),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .fi_tag(fi_tag), .fi_data(fi_data), .err_clr(err_clr), .err_cnt(err_cnt)
   );

   int vectors = 0;
   int fails   = 0;
   int rd_count = 0;
   int wr_count = 0;
   int cyc = 0;
   logic [1:0]  rd_offs [$];
   logic [31:0] bmem    [4096];
   logic [31:0] ref_mem [4096];

   typedef struct { logic ld; logic [31:0] d; string rq; } exp_t;
   exp_t exp_q [$];

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   function automatic logic [11:0] mk(input int t, input int i, input int o);
      return {7'(t), 3'(i), 2'(o)};
   endfunction

   // memory model: acknowledges one cycle after a request is seen
   always @(posedge clk) begin
      if (rst) begin
         mem_ack <= 1'b0;
      end else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && !mem_ack) begin
            if (mem_we) begin
               bmem[mem_addr] <= mem_wdata;
               wr_count <= wr_count + 1;
            end else begin
               mem_rdata <= bmem[mem_addr];
               rd_count  <= rd_count + 1;
               rd_offs.push_back(mem_addr[1:0]);
            end
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && cpu_ack) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected ack", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.ld) chk(cpu_rdata == e.d, e.rq, cpu_rdata, e.d);
         end
      end
   end

   task automatic access(input logic we, input logic [11:0] a, input logic [31:0] wd,
                         input logic ft, input logic fd, input logic clr_now,
                         input string rq, output int nrd, output int nwr);
      int r0, w0;
      bit done;
      exp_t e;
      @(negedge clk);
      r0 = rd_count; w0 = wr_count;
      e.ld = !we; e.d = we ? 32'h0 : ref_mem[a]; e.rq = rq;
      exp_q.push_back(e);
      if (we) ref_mem[a] = wd;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      fi_tag = ft; fi_data = fd; err_clr = clr_now;
      done = 1'b0;
      for (int k = 0; k < 200 && !done; k++) begin
         @(negedge clk);
         err_clr = 1'b0;
         if (cpu_ack) done = 1'b1;
      end
      if (!done) chk(1'b0, {rq, " ack timeout"}, 0, 1);
      cpu_req = 1'b0; fi_tag = 1'b0; fi_data = 1'b0;
      nrd = rd_count - r0; nwr = wr_count - w0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int nr, nw, e0;
      for (int i = 0; i < 4096; i++) begin
         bmem[i]    = {i[11:0], 8'h5A, ~i[11:0]} ^ 32'h3C3C_0000;
         ref_mem[i] = bmem[i];
      end
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R12 reset state
      chk(err_cnt == 0, "R12 count after reset", err_cnt, 0);
      chk(!mem_req && !cpu_ack, "R12 idle outputs", {mem_req, cpu_ack}, 0);

      // R1 miss refill, requested word 2, order 0..3
      rd_offs.delete();
      access(1'b0, mk(5,1,2), 0, 0, 0, 0, "R1 miss data", nr, nw);
      chk(nr == 4, "R1 refill reads", nr, 4);
      chk(rd_offs.size() == 4 && rd_offs[0] == 0 && rd_offs[1] == 1 &&
          rd_offs[2] == 2 && rd_offs[3] == 3, "R1 ascending order",
          rd_offs.size() > 0 ? rd_offs[0] : 9, 0);

      // R2 hit
      access(1'b0, mk(5,1,0), 0, 0, 0, 0, "R2 hit data", nr, nw);
      chk(nr == 0 && nw == 0, "R2 no memory traffic", nr + nw, 0);

      // R6 R7 store hit
      access(1'b1, mk(5,1,3), 32'hCAFE_0103, 0, 0, 0, "R6 store", nr, nw);
      chk(nw == 1 && nr == 0, "R6 one write", nw, 1);
      chk(bmem[mk(5,1,3)] == 32'hCAFE_0103, "R6 memory written", bmem[mk(5,1,3)], 32'hCAFE_0103);
      e0 = err_cnt;
      access(1'b0, mk(5,1,3), 0, 0, 0, 0, "R7 updated word", nr, nw);
      chk(nr == 0, "R7 store hit keeps line", nr, 0);
      chk(err_cnt == e0, "R3 store parity consistent", err_cnt, e0);

      // R8 store miss, same index different tag
      access(1'b1, mk(9,1,0), 32'h1234_9100, 0, 0, 0, "R8 store", nr, nw);
      chk(nw == 1, "R8 write through", nw, 1);
      access(1'b0, mk(5,1,1), 0, 0, 0, 0, "R8 old line data", nr, nw);
      chk(nr == 0, "R8 no allocate", nr, 0);
      access(1'b0, mk(9,1,0), 0, 0, 0, 0, "R8 stored value from memory", nr, nw);
      chk(nr == 4, "R8 later load misses", nr, 4);

      // R4 R11 tag parity fault
      e0 = err_cnt;
      access(1'b0, mk(3,2,0), 0, 1, 0, 0, "R11 fill data", nr, nw);
      chk(nr == 4 && err_cnt == e0, "R11 fresh fill no error", err_cnt, e0);
      access(1'b0, mk(3,2,1), 0, 0, 0, 0, "R4 data after tag error", nr, nw);
      chk(nr == 4, "R4 refill on tag error", nr, 4);
      chk(err_cnt == e0 + 1, "R4 count", err_cnt, e0 + 1);
      access(1'b0, mk(3,2,2), 0, 0, 0, 0, "R4 repaired data", nr, nw);
      chk(nr == 0 && err_cnt == e0 + 1, "R4 line repaired", nr, 0);

      // R5 R11 data parity fault
      e0 = err_cnt;
      access(1'b0, mk(4,3,0), 0, 0, 1, 0, "R11 fill data", nr, nw);
      access(1'b0, mk(4,3,2), 0, 0, 0, 0, "R5 data after word error", nr, nw);
      chk(nr == 4, "R5 refill on word error", nr, 4);
      chk(err_cnt == e0 + 1, "R5 count", err_cnt, e0 + 1);
      access(1'b0, mk(4,3,2), 0, 0, 0, 0, "R5 repaired data", nr, nw);
      chk(nr == 0, "R5 line repaired", nr, 0);

      // R3 parity written by a store hit (inverted via fi_data)
      access(1'b1, mk(4,3,1), 32'hBEEF_4301, 0, 1, 0, "R3 store", nr, nw);
      access(1'b0, mk(4,3,1), 0, 0, 0, 0, "R3 reload after bad store parity", nr, nw);
      chk(nr == 4 && err_cnt == e0 + 2, "R3 store parity checked", err_cnt, e0 + 2);

      // R10 clear
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk(err_cnt == 0, "R10 clear", err_cnt, 0);

      // R10 clear together with a detection
      access(1'b0, mk(6,4,0), 0, 1, 0, 0, "R10 setup data", nr, nw);
      access(1'b0, mk(6,4,1), 0, 0, 0, 1, "R10 data", nr, nw);
      chk(err_cnt == 1, "R10 clear with error", err_cnt, 1);

      // R9 saturation
      for (int i = 0; i < 300; i++)
         access(1'b0, mk(7,5,0), 0, 1, 0, 0, "R9 data", nr, nw);
      chk(err_cnt == 8'hFF, "R9 saturate", err_cnt, 255);

      // R12 reset invalidates lines
      do_reset();
      chk(err_cnt == 0, "R12 count cleared", err_cnt, 0);
      access(1'b0, mk(5,1,0), 0, 0, 0, 0, "R12 data", nr, nw);
      chk(nr == 4, "R12 lines invalid", nr, 4);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all acks seen", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule